// File: doc/BRIEF.md
# Pseudo-Binary Weight Quantizer

This block turns one target weight into an on/off pattern for a row of NBITS resistive cells. Each cell, when left in its low-resistance state, contributes its own measured normalized resistance times its binary bit weight 2^i. These values are close to 1.0 but are not exactly 1.0. A cell driven to the high-resistance state contributes nothing. The block walks the bits from the most significant to the least significant, one clock per bit. At each bit it decides whether keeping the cell low brings the sum closer to the target without overshooting it, and it updates the remaining weight as it goes.

All values are unsigned fixed point with FRAC fractional bits. The default is 8, so 1.0 is 256. The weight has NBITS integer bits. Each resistance has RINT integer bits. Lane i of the packed resistance input, at bits [i*RW +: RW], belongs to bit weight 2^i.

A job is accepted when `in_valid` is high and `in_ready` is high. Exactly NBITS clock edges later, `out_valid` pulses for one cycle with three results:
- the pattern, where bit i = 1 means "leave cell i low-resistance";
- the quantized value;
- the signed final error.

Top module: `pbq_quantizer`

## Requirements
- R1: After reset, and whenever no job is in flight, `in_ready` is 1. A job accepted on a clock edge raises `out_valid` for exactly one cycle, after exactly NBITS further clock edges, and `in_ready` is 1 in that cycle.
- R2: While a job is in flight (`in_ready` = 0), `in_valid` and the data inputs are ignored: the in-flight result is unchanged and no extra `out_valid` pulse appears.
- R3: `q_value` equals the sum, over cells i with `cell_low[i]` = 1, of r_i·2^i. Cells with `cell_low[i]` = 0 add exactly zero.
- R4: `q_error` (two's complement, FRAC fractional bits) equals the weight minus `q_value`.
- R5: A cell whose normalized resistance is at or below REJECT_THR (default 0.5, code 128) always gets `cell_low[i]` = 0, even if it would fit.
- R6: A cell gets `cell_low[i]` = 0 when its contribution r_i·2^i exceeds the remaining weight by more than MARGIN (default 0.5, code 128).
- R7: A cell gets `cell_low[i]` = 0 when its contribution is larger than twice the remaining weight.
- R8: Otherwise the cell is kept low-resistance. Its contribution is subtracted from the remaining weight before the next lower bit is decided, starting from the MSB.
- R9: Weight 13.4 (code 3430) with resistances MSB to LSB of 1.05, 1.1, 1.125 and 0.93 (codes 269, 282, 288, 238) gives pattern 4'b1101, `q_value` 3518 and `q_error` −88.
- R10: During and right after reset, `out_valid`, `cell_low`, `q_value` and `q_error` are 0.
- R11: `cell_low`, `q_value` and `q_error` hold their last values until the next `out_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Job request |
| in_ready | output | 1 | High when a new job can be accepted |
| weight_in | input | NBITS+FRAC (12) | Target weight, unsigned fixed point |
| res_in | input | NBITS*(RINT+FRAC) (40) | Packed normalized resistances, lane i for bit 2^i |
| out_valid | output | 1 | One-cycle result strobe |
| cell_low | output | NBITS (4) | 1 = leave cell low-resistance |
| q_value | output | RINT+FRAC+NBITS (14) | Quantized value |
| q_error | output | SW (15) | Weight minus quantized value, two's complement |

## Verification
The hardest situations to reach from the ports are the ones where exactly one of the three rejection rules decides a bit while the other two would keep it:
- a resistance exactly at the threshold that would otherwise fit;
- a contribution that overshoots by more than the margin but is not twice the remainder;
- a small remainder where the contribution is within the margin yet more than double.

Each of these is reached by choosing weights and per-lane resistances by hand, so that earlier kept bits leave a chosen remainder at the bit under test. A randomized sweep then compares every result against an independent model of the rules. A job that is poked with new data while busy shows that inputs are ignored during a run.

// File: rtl/pbq_pkg.sv
// Shared types for the pseudo-binary weight quantizer.
package pbq_pkg;

    // Control state: waiting for a job, or walking the bits.
    typedef enum logic [0:0] {
        PBQ_IDLE = 1'b0,
        PBQ_RUN  = 1'b1
    } pbq_state_e;

endpackage

// File: rtl/pbq_ctrl.sv
// Sequencer: accepts a job when idle, then steps a bit index from NBITS-1
// down to 0, one clock per bit, and raises a one-cycle done strobe.
// Assumes NBITS >= 1.
module pbq_ctrl
    import pbq_pkg::*;
#(
    parameter int NBITS = 4,
    localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    output logic          load,
    output logic          step,
    output logic          last,
    output logic [IW-1:0] bit_idx,
    output logic          done
);

    pbq_state_e state;

    // Handshake and phase decode.
    always_comb begin
        in_ready = (state == PBQ_IDLE);
        load     = in_valid && in_ready;
        step     = (state == PBQ_RUN);
        last     = step && (bit_idx == '0);
    end

    // State, bit index and completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= PBQ_IDLE;
            bit_idx <= '0;
            done    <= 1'b0;
        end else begin
            done <= last;
            if (load) begin
                state   <= PBQ_RUN;
                bit_idx <= IW'(NBITS - 1);
            end else if (last) begin
                state <= PBQ_IDLE;
            end else if (step) begin
                bit_idx <= bit_idx - IW'(1);
            end
        end
    end

endmodule

// File: rtl/pbq_lane_mux.sv
// Picks the resistance lane for the current bit and forms its contribution
// r_i * 2^i. Lane i sits at r_flat[i*RW +: RW].
module pbq_lane_mux #(
    parameter int NBITS = 4,
    parameter int RW    = 10,
    localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1,
    localparam int CW = RW + NBITS - 1
) (
    input  logic [NBITS*RW-1:0] r_flat,
    input  logic [IW-1:0]       bit_idx,
    output logic [RW-1:0]       r_lane,
    output logic [CW-1:0]       contrib
);

    logic [RW-1:0] lanes [NBITS];
    logic [CW-1:0] cand  [NBITS];

    // One pre-shifted candidate per lane.
    for (genvar g = 0; g < NBITS; g++) begin : g_lane
        assign lanes[g] = r_flat[g*RW +: RW];
        assign cand[g]  = {{(NBITS-1){1'b0}}, lanes[g]} << g;
    end

    // Select the lane of the bit being decided.
    always_comb begin
        r_lane  = lanes[bit_idx];
        contrib = cand[bit_idx];
    end

endmodule

// File: rtl/pbq_bit_decide.sv
// Keep/drop decision for one cell. The cell is dropped (set high-resistance)
// when its resistance is at or below the rejection threshold, when its
// contribution overshoots the residual by more than the margin, or when its
// contribution exceeds twice the residual. The residual is signed.
module pbq_bit_decide #(
    parameter int          RW         = 10,
    parameter int          CW         = 13,
    parameter int          SW         = 15,
    parameter int unsigned REJECT_THR = 128,
    parameter int unsigned MARGIN     = 128,
    localparam int XW = SW + 2
) (
    input  logic [RW-1:0] r_lane,
    input  logic [CW-1:0] contrib,
    input  logic [SW-1:0] residual,
    output logic          keep
);

    localparam logic [RW-1:0] THR_V    = RW'(REJECT_THR);
    localparam logic [XW-1:0] MARGIN_V = XW'(MARGIN);

    logic [XW-1:0] c_x, res_x, diff_x, res2_x;
    logic          rej_low, rej_over, rej_twice;

    // Extend operands and evaluate the three drop rules.
    always_comb begin
        c_x       = XW'(contrib);
        res_x     = {{2{residual[SW-1]}}, residual};
        diff_x    = c_x - res_x;
        res2_x    = res_x << 1;
        rej_low   = (r_lane <= THR_V);
        rej_over  = ($signed(diff_x) > $signed(MARGIN_V));
        rej_twice = ($signed(c_x) > $signed(res2_x));
        keep      = !(rej_low || rej_over || rej_twice);
    end

endmodule

// File: rtl/pbq_quantizer.sv
// Pseudo-binary weight quantizer top. Latches a weight and NBITS normalized
// resistances, decides one cell per clock from MSB to LSB, and presents the
// keep pattern, the quantized value and the signed error together with a
// one-cycle out_valid strobe. Values are unsigned fixed point with FRAC
// fractional bits; the error is two's complement. Inputs are sampled only
// at acceptance.
module pbq_quantizer #(
    parameter int          NBITS      = 4,
    parameter int          FRAC       = 8,
    parameter int          RINT       = 2,
    parameter int unsigned REJECT_THR = 128,
    parameter int unsigned MARGIN     = 128,
    localparam int RW  = RINT + FRAC,
    localparam int WW  = NBITS + FRAC,
    localparam int CW  = RW + NBITS - 1,
    localparam int QW  = CW + 1,
    localparam int SW  = ((WW > CW) ? WW : CW) + 2,
    localparam int RFW = NBITS * RW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WW-1:0]    weight_in,
    input  logic [RFW-1:0]   res_in,
    output logic             out_valid,
    output logic [NBITS-1:0] cell_low,
    output logic [QW-1:0]    q_value,
    output logic [SW-1:0]    q_error
);

    localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1;

    logic             load, step, last;
    logic [IW-1:0]    bit_idx;
    logic [RFW-1:0]   r_hold;
    logic [SW-1:0]    residual, res_nxt;
    logic [QW-1:0]    acc, acc_nxt;
    logic [NBITS-1:0] cells, cells_nxt;
    logic [RW-1:0]    r_lane;
    logic [CW-1:0]    contrib;
    logic             keep;

    pbq_ctrl #(.NBITS(NBITS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .load     (load),
        .step     (step),
        .last     (last),
        .bit_idx  (bit_idx),
        .done     (out_valid)
    );

    pbq_lane_mux #(.NBITS(NBITS), .RW(RW)) u_mux (
        .r_flat  (r_hold),
        .bit_idx (bit_idx),
        .r_lane  (r_lane),
        .contrib (contrib)
    );

    pbq_bit_decide #(
        .RW(RW), .CW(CW), .SW(SW),
        .REJECT_THR(REJECT_THR), .MARGIN(MARGIN)
    ) u_dec (
        .r_lane   (r_lane),
        .contrib  (contrib),
        .residual (residual),
        .keep     (keep)
    );

    // Next working values after the current bit's decision.
    always_comb begin
        res_nxt   = residual;
        acc_nxt   = acc;
        cells_nxt = cells;
        if (keep) begin
            res_nxt            = residual - SW'(contrib);
            acc_nxt            = acc + QW'(contrib);
            cells_nxt[bit_idx] = 1'b1;
        end
    end

    // Working registers: load on acceptance, update on each bit step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_hold   <= '0;
            residual <= '0;
            acc      <= '0;
            cells    <= '0;
        end else if (load) begin
            r_hold   <= res_in;
            residual <= SW'(weight_in);
            acc      <= '0;
            cells    <= '0;
        end else if (step) begin
            residual <= res_nxt;
            acc      <= acc_nxt;
            cells    <= cells_nxt;
        end
    end

    // Result registers: captured on the last bit, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_low <= '0;
            q_value  <= '0;
            q_error  <= '0;
        end else if (last) begin
            cell_low <= cells_nxt;
            q_value  <= acc_nxt;
            q_error  <= res_nxt;
        end
    end

endmodule

// File: rtl/pbq_quantizer_chk.sv
// Property checker for pbq_quantizer, attached by bind. Captures the job at
// acceptance and checks timing, sum, error and rejection at completion.
module pbq_quantizer_chk #(
    parameter int          NBITS      = 4,
    parameter int          RW         = 10,
    parameter int          WW         = 12,
    parameter int          QW         = 14,
    parameter int          SW         = 15,
    parameter int unsigned REJECT_THR = 128
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_ready,
    input logic [WW-1:0]       weight_in,
    input logic [NBITS*RW-1:0] res_in,
    input logic                out_valid,
    input logic [NBITS-1:0]    cell_low,
    input logic [QW-1:0]       q_value,
    input logic [SW-1:0]       q_error
);

    localparam int XW = SW + 2;
    localparam int KW = $clog2(NBITS + 2) + 1;

    logic [WW-1:0]       w_cap;
    logic [NBITS*RW-1:0] r_cap;
    logic [KW-1:0]       since;
    logic [QW-1:0]       sum_q;
    logic [NBITS-1:0]    rej_mask;
    logic [XW-1:0]       err_x, qv_x, w_x;

    // Capture the accepted job and count edges since acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_cap <= '0;
            r_cap <= '0;
            since <= '0;
        end else if (in_valid && in_ready) begin
            w_cap <= weight_in;
            r_cap <= res_in;
            since <= KW'(1);
        end else if (since == KW'(NBITS + 1)) begin
            since <= '0;
        end else if (since != '0) begin
            since <= since + KW'(1);
        end
    end

    // Independent sum of kept contributions and the mask of rejected lanes.
    always_comb begin
        sum_q = '0;
        for (int i = 0; i < NBITS; i++) begin
            rej_mask[i] = (r_cap[i*RW +: RW] <= RW'(REJECT_THR));
            if (cell_low[i]) sum_q = sum_q + (QW'(r_cap[i*RW +: RW]) << i);
        end
        err_x = {{2{q_error[SW-1]}}, q_error};
        qv_x  = XW'(q_value);
        w_x   = XW'(w_cap);
    end

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);                                // R1
    AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_ready);                                  // R1
    AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (since == KW'(NBITS + 1)));                 // R2
    AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (q_value == sum_q));                        // R3
    AST_ERROR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((err_x + qv_x) == w_x));                   // R4
    AST_REJECT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((cell_low & rej_mask) == '0));             // R5
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(q_value) && $stable(cell_low)
                        && $stable(q_error)));                    // R11

endmodule

bind pbq_quantizer pbq_quantizer_chk #(
    .NBITS(NBITS), .RW(RW), .WW(WW), .QW(QW), .SW(SW),
    .REJECT_THR(REJECT_THR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .weight_in (weight_in),
    .res_in    (res_in),
    .out_valid (out_valid),
    .cell_low  (cell_low),
    .q_value   (q_value),
    .q_error   (q_error)
);

// File: tb/pbq_quantizer_bench.sv
// Directed bench for pbq_quantizer: one task per scenario, each checking
// its own results against a model written from the requirements.
module pbq_quantizer_bench;

    localparam int NBITS = 4;
    localparam int FRAC  = 8;
    localparam int RINT  = 2;
    localparam int THR   = 128;
    localparam int MARG  = 128;
    localparam int RW    = RINT + FRAC;
    localparam int WW    = NBITS + FRAC;
    localparam int CW    = RW + NBITS - 1;
    localparam int QW    = CW + 1;
    localparam int SW    = ((WW > CW) ? WW : CW) + 2;
    localparam int RFW   = NBITS * RW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [WW-1:0]    weight_in = '0;
    logic [RFW-1:0]   res_in = '0;
    logic             out_valid;
    logic [NBITS-1:0] cell_low;
    logic [QW-1:0]    q_value;
    logic [SW-1:0]    q_error;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    logic [31:0] seed = 32'h1234_5678;

    pbq_quantizer #(
        .NBITS(NBITS), .FRAC(FRAC), .RINT(RINT),
        .REJECT_THR(THR), .MARGIN(MARG)
    ) u_pbq_quantizer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .weight_in(weight_in), .res_in(res_in), .out_valid(out_valid),
        .cell_low(cell_low), .q_value(q_value), .q_error(q_error)
    );

    always #4 clk = ~clk;

    // Watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [RFW-1:0] pack(input int r3, input int r2, input int r1, input int r0);
        logic [RFW-1:0] v;
        v = {RW'(r3), RW'(r2), RW'(r1), RW'(r0)};
        return v;
    endfunction

    // Reference from the rules: MSB first; drop on low resistance, overshoot
    // beyond margin, or more than twice the remainder; else keep.
    task automatic model(input logic [WW-1:0] w, input logic [RFW-1:0] r,
                         output logic [NBITS-1:0] cells, output longint q, output longint e);
        longint rem, c, ri;
        rem = longint'(w); q = 0; cells = '0;
        for (int i = NBITS - 1; i >= 0; i--) begin
            ri = longint'(r[i*RW +: RW]);
            c  = ri * (longint'(1) << i);
            if (!(ri <= THR || (c - rem) > MARG || c > 2 * rem)) begin
                cells[i] = 1'b1; q += c; rem -= c;
            end
        end
        e = rem;
    endtask

    function automatic longint err_val(input logic [SW-1:0] v);
        return longint'($signed(v));
    endfunction

    // Drive one job, check the strobe timing, optionally poke while busy.
    task automatic run_op(input logic [WW-1:0] w, input logic [RFW-1:0] r, input bit poke);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; weight_in = w; res_in = r;
        @(negedge clk);
        if (poke) begin
            weight_in = ~w; res_in = ~r;
        end else begin
            in_valid = 1'b0;
        end
        for (int k = 1; k <= NBITS; k++) begin
            @(negedge clk);
            if (k == NBITS - 1) in_valid = 1'b0;
            if (k < NBITS) check(out_valid == 1'b0, "R1 early strobe", out_valid, 0);
            else begin
                check(out_valid == 1'b1, "R1 strobe", out_valid, 1);
                check(in_ready == 1'b1, "R1 ready at done", in_ready, 1);
            end
        end
    endtask

    task automatic expect_result(input logic [WW-1:0] w, input logic [RFW-1:0] r, input string req);
        logic [NBITS-1:0] ec; longint eq, ee;
        model(w, r, ec, eq, ee);
        check(cell_low == ec, {req, " pattern"}, cell_low, ec);
        check(longint'(q_value) == eq, "R3 q_value", q_value, eq);
        check(err_val(q_error) == ee, "R4 q_error", err_val(q_error), ee);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 0 && cell_low == 0 && q_value == 0 && q_error == 0,
              "R10 reset outputs", {out_valid, cell_low, q_value}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
        check(out_valid == 1'b0, "R10 no strobe", out_valid, 0);
    endtask

    task automatic t_worked();
        logic [RFW-1:0] r;
        r = pack(269, 282, 288, 238);
        run_op(WW'(3430), r, 1'b0);
        check(cell_low == 4'b1101, "R9 pattern", cell_low, 4'b1101);
        check(q_value == 3518, "R9 q_value", q_value, 3518);
        check(err_val(q_error) == -88, "R9 q_error", err_val(q_error), -88);
        // R8: with the MSB kept, bit 1 sees remainder 150 and is dropped.
        check(cell_low[1] == 1'b0, "R8 sequential remainder", cell_low[1], 0);
    endtask

    task automatic t_binary();
        logic [RFW-1:0] r;
        r = pack(256, 256, 256, 256);
        run_op(WW'(1280), r, 1'b0);
        check(cell_low == 4'b0101, "R8 ideal cells", cell_low, 4'b0101);
        check(err_val(q_error) == 0, "R4 zero error", err_val(q_error), 0);
        run_op(WW'(0), r, 1'b0);
        check(cell_low == 4'b0000 && q_value == 0, "R3 zero weight", q_value, 0);
    endtask

    task automatic t_reject();
        logic [RFW-1:0] r;
        r = pack(256, 256, 128, 256);   // lane 1 exactly at threshold
        run_op(WW'(3840), r, 1'b0);
        check(cell_low == 4'b1101, "R5 reject at threshold", cell_low, 4'b1101);
        check(q_value == 3328, "R5 q_value", q_value, 3328);
        check(err_val(q_error) == 512, "R5 q_error", err_val(q_error), 512);
        r = pack(256, 256, 129, 256);   // just above: lane 1 kept
        run_op(WW'(3840), r, 1'b0);
        check(cell_low == 4'b1111, "R5 above threshold kept", cell_low, 4'b1111);
    endtask

    task automatic t_margin();
        logic [RFW-1:0] r;
        r = pack(256, 256, 384, 256);   // bit2 c=4 vs rem 2; bit1 c=3 vs rem 2
        run_op(WW'(512), r, 1'b0);
        check(cell_low == 4'b0001, "R6 overshoot dropped", cell_low, 4'b0001);
        check(err_val(q_error) == 256, "R6 q_error", err_val(q_error), 256);
    endtask

    task automatic t_twice();
        logic [RFW-1:0] r;
        r = pack(256, 256, 256, 192);   // bit0 c=0.75 vs rem 0.25
        run_op(WW'(64), r, 1'b0);
        check(cell_low == 4'b0000, "R7 more than twice dropped", cell_low, 4'b0000);
        check(err_val(q_error) == 64, "R7 q_error", err_val(q_error), 64);
        r = pack(256, 256, 256, 160);   // c=0.625 vs rem 0.3125: not > twice
        run_op(WW'(80), r, 1'b0);
        check(cell_low == 4'b0001, "R7 at limit kept", cell_low, 4'b0001);
        check(err_val(q_error) == -80, "R7 negative error", err_val(q_error), -80);
    endtask

    task automatic t_busy();
        logic [RFW-1:0] r;
        int extra;
        r = pack(269, 282, 288, 238);
        run_op(WW'(3430), r, 1'b1);
        expect_result(WW'(3430), r, "R2 busy poke");
        extra = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (out_valid) extra++;
        end
        check(extra == 0, "R2 no extra strobe", extra, 0);
        check(cell_low == 4'b1101, "R11 result held", cell_low, 4'b1101);
    endtask

    task automatic t_sweep();
        logic [WW-1:0] w;
        logic [RFW-1:0] r;
        for (int n = 0; n < 40; n++) begin
            for (int i = 0; i < NBITS; i++) begin
                seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
                r[i*RW +: RW] = RW'(112 + (seed % 288));
            end
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            w = WW'(seed);
            run_op(w, r, 1'b0);
            expect_result(w, r, "R8 sweep");
        end
    endtask

    initial begin
        t_reset();
        t_worked();
        t_binary();
        t_reject();
        t_margin();
        t_twice();
        t_busy();
        t_sweep();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule